// File: doc/BRIEF.md
# Saturating Priority Replacement Unit

This block keeps the replacement order for every set of a set-associative cache whose ways are ranked by a saturating priority. Each way of a set holds a distinct rank. A hit lifts the accessed way by a single step, trading places with the way just above it. A fill puts the new entry at the bottom. The victim for a set is therefore always the way that has been least proven by repeated use. Entries that are used once and never again leave first, while entries that are used often climb and stay.

The cache controller drives one update per cycle at most. Each update names a set, a way and whether it was a hit or a fill. Independently, the controller presents a lookup set and reads back the victim way and the full rank vector of that set. Tag and data storage live outside this block.

Top module: `sp_repl_unit`

## Requirements
- R1: During and after reset, in every set, way i holds rank i. Rank 0 is the lowest and WAYS-1 the highest, and the rank of way i appears at `look_ranks[i*WAY_W +: WAY_W]`.
- R2: `victim_way` is the way of set `look_set` whose rank is 0. It follows `look_set` combinationally.
- R3: A hit (`upd_fill`=0) on a way with rank r below WAYS-1 gives that way rank r+1 and gives rank r to the way that held r+1. Every other way of the set keeps its rank.
- R4: A hit on the way already at rank WAYS-1 leaves every rank of the set unchanged.
- R5: A fill (`upd_fill`=1) into a way with rank r gives that way rank 0, and each way whose rank was below r moves up by one. A fill into the rank-0 way therefore changes nothing.
- R6: An update changes only the set named by `upd_set`. All other sets keep their ranks.
- R7: The ranks of every set always form a permutation of 0..WAYS-1.
- R8: An update takes effect at the next clock edge, so an update in the following cycle to the same set starts from the already-updated ranks.
- R9: While `upd_valid` is low, no rank changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | An update event is present this cycle |
| upd_fill | input | 1 | 1 = fill into way, 0 = hit on way |
| upd_set | input | SET_W | Set the update applies to |
| upd_way | input | WAY_W | Way the update applies to |
| look_set | input | SET_W | Set whose state is presented |
| victim_way | output | WAY_W | Way of `look_set` at rank 0 |
| look_ranks | output | WAYS*WAY_W | Ranks of all ways of `look_set` |

## Verification
The hardest situation to reach is a set whose ranks are thoroughly shuffled, with fills landing on ways in the middle of the order and hits landing on the top way. From reset, each set sits in the identity order, and only a long mix of hits and fills on one set moves it far from that order. The stimulus therefore first replays the short worked sequence (two climbs, a fill on the new victim, a hit at the top). It then walks a back-to-back vector table and a long pseudo-random stream that is concentrated on few sets. Every resulting rank vector is compared against a model kept in the bench.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic {
        UPD_HIT  = 1'b0,
        UPD_FILL = 1'b1
    } upd_kind_e;
endpackage

// File: rtl/sp_rank_update.sv
module sp_rank_update
    import sp_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS*WAY_W-1:0] cur_ranks,
    input  upd_kind_e             kind,
    input  logic [WAY_W-1:0]      way,
    output logic [WAYS*WAY_W-1:0] nxt_ranks
);
    localparam logic [WAY_W-1:0] TOP = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] sel_rank;
    logic [WAY_W-1:0] one_up;

    always_comb begin
        sel_rank = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (WAY_W'(i) == way) sel_rank = cur_ranks[i*WAY_W +: WAY_W];
        end
        one_up = sel_rank + WAY_W'(1);
    end

    always_comb begin
        nxt_ranks = cur_ranks;
        unique case (kind)
            UPD_HIT: begin
                if (sel_rank != TOP) begin
                    for (int i = 0; i < WAYS; i++) begin
                        if (WAY_W'(i) == way)
                            nxt_ranks[i*WAY_W +: WAY_W] = one_up;
                        else if (cur_ranks[i*WAY_W +: WAY_W] == one_up)
                            nxt_ranks[i*WAY_W +: WAY_W] = sel_rank;
                    end
                end
            end
            UPD_FILL: begin
                for (int i = 0; i < WAYS; i++) begin
                    if (WAY_W'(i) == way)
                        nxt_ranks[i*WAY_W +: WAY_W] = '0;
                    else if (cur_ranks[i*WAY_W +: WAY_W] < sel_rank)
                        nxt_ranks[i*WAY_W +: WAY_W] = cur_ranks[i*WAY_W +: WAY_W] + WAY_W'(1);
                end
            end
            default: nxt_ranks = cur_ranks;
        endcase
    end
endmodule

// File: rtl/sp_victim_pick.sv
module sp_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS*WAY_W-1:0] ranks,
    output logic [WAY_W-1:0]      victim
);
    always_comb begin
        victim = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (ranks[i*WAY_W +: WAY_W] == '0) victim = WAY_W'(i);
        end
    end
endmodule

// File: rtl/sp_repl_unit.sv
module sp_repl_unit
    import sp_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_valid,
    input  logic                  upd_fill,
    input  logic [SET_W-1:0]      upd_set,
    input  logic [WAY_W-1:0]      upd_way,
    input  logic [SET_W-1:0]      look_set,
    output logic [WAY_W-1:0]      victim_way,
    output logic [WAYS*WAY_W-1:0] look_ranks
);
    localparam int RANK_W = WAYS * WAY_W;

    function automatic logic [RANK_W-1:0] identity_ranks();
        logic [RANK_W-1:0] v;
        for (int i = 0; i < WAYS; i++) v[i*WAY_W +: WAY_W] = WAY_W'(i);
        return v;
    endfunction

    localparam logic [RANK_W-1:0] INIT_RANKS = identity_ranks();

    logic [RANK_W-1:0] rank_q [SETS];
    logic [RANK_W-1:0] cur_ranks;
    logic [RANK_W-1:0] nxt_ranks;
    upd_kind_e         kind;

    assign kind      = upd_fill ? UPD_FILL : UPD_HIT;
    assign cur_ranks = rank_q[upd_set];

    sp_rank_update #(.WAYS(WAYS), .WAY_W(WAY_W)) u_update (
        .cur_ranks (cur_ranks),
        .kind      (kind),
        .way       (upd_way),
        .nxt_ranks (nxt_ranks)
    );

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_set
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rank_q[s] <= INIT_RANKS;
                else if (upd_valid && (upd_set == SET_W'(s)))
                    rank_q[s] <= nxt_ranks;
            end
        end
    endgenerate

    assign look_ranks = rank_q[look_set];

    sp_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .ranks  (look_ranks),
        .victim (victim_way)
    );
endmodule

// File: rtl/sp_repl_chk.sv
module sp_repl_chk #(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  upd_valid,
    input logic                  upd_fill,
    input logic [SET_W-1:0]      upd_set,
    input logic [WAY_W-1:0]      upd_way,
    input logic [SET_W-1:0]      look_set,
    input logic [WAY_W-1:0]      victim_way,
    input logic [WAYS*WAY_W-1:0] look_ranks
);
    localparam logic [WAY_W-1:0] TOP = WAY_W'(WAYS - 1);

    function automatic logic [WAY_W-1:0] rank_of(logic [WAYS*WAY_W-1:0] v, logic [WAY_W-1:0] w);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int i = 0; i < WAYS; i++) if (WAY_W'(i) == w) r = v[i*WAY_W +: WAY_W];
        return r;
    endfunction

    logic             perm_ok;
    logic [WAY_W-1:0] upd_rank;
    logic             same_set;

    always_comb begin
        perm_ok = 1'b1;
        for (int v = 0; v < WAYS; v++) begin
            int n;
            n = 0;
            for (int i = 0; i < WAYS; i++)
                if (look_ranks[i*WAY_W +: WAY_W] == WAY_W'(v)) n++;
            if (n != 1) perm_ok = 1'b0;
        end
    end

    assign upd_rank = rank_of(look_ranks, upd_way);
    assign same_set = (look_set == upd_set);

    // R7
    perm_chk: assert property (@(posedge clk) disable iff (!rst_n) perm_ok);

    // R2
    victim_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rank_of(look_ranks, victim_way) == '0);

    // R3
    hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_fill && same_set && upd_rank != TOP) |=>
        (look_set != $past(look_set)) ||
        (rank_of(look_ranks, $past(upd_way)) == $past(upd_rank) + WAY_W'(1)));

    // R4
    top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_fill && same_set && upd_rank == TOP) |=>
        (look_set != $past(look_set)) || (look_ranks == $past(look_ranks)));

    // R5
    fill_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_fill && same_set) |=>
        (look_set != $past(look_set)) || (rank_of(look_ranks, $past(upd_way)) == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=>
        (look_set != $past(look_set)) || (look_ranks == $past(look_ranks)));
endmodule

bind sp_repl_unit sp_repl_chk #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .SET_W(SET_W)) u_chk (.*);

// File: tb/sp_repl_unit_bench.sv
module sp_repl_unit_bench;
    localparam int PERIOD = 10;
    localparam int WAYS   = 4;
    localparam int SETS   = 8;
    localparam int WAY_W  = 2;
    localparam int SET_W  = 3;
    localparam int VEC_W  = 1 + SET_W + WAY_W;
    localparam int NVEC   = 16;
    // {fill, set, way}: back-to-back events, mostly on sets 2 and 3
    localparam logic [VEC_W-1:0] VECS [NVEC] = '{
        {1'b0, 3'd2, 2'd0}, {1'b0, 3'd2, 2'd0}, {1'b0, 3'd2, 2'd0},
        {1'b0, 3'd2, 2'd0}, {1'b1, 3'd2, 2'd2}, {1'b0, 3'd2, 2'd3},
        {1'b1, 3'd3, 2'd3}, {1'b1, 3'd3, 2'd1}, {1'b0, 3'd3, 2'd3},
        {1'b0, 3'd3, 2'd3}, {1'b1, 3'd2, 2'd1}, {1'b0, 3'd2, 2'd1},
        {1'b1, 3'd3, 2'd0}, {1'b0, 3'd7, 2'd1}, {1'b1, 3'd7, 2'd3},
        {1'b0, 3'd2, 2'd2}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  upd_valid = 1'b0;
    logic                  upd_fill = 1'b0;
    logic [SET_W-1:0]      upd_set = '0;
    logic [WAY_W-1:0]      upd_way = '0;
    logic [SET_W-1:0]      look_set = '0;
    logic [WAY_W-1:0]      victim_way;
    logic [WAYS*WAY_W-1:0] look_ranks;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int mdl [SETS][WAYS];

    always #(PERIOD/2) clk = ~clk;

    sp_repl_unit #(.WAYS(WAYS), .SETS(SETS)) u_sp_repl_unit (.*);

    function automatic logic [WAYS*WAY_W-1:0] exp_vec(int s);
        logic [WAYS*WAY_W-1:0] v;
        for (int i = 0; i < WAYS; i++) v[i*WAY_W +: WAY_W] = WAY_W'(mdl[s][i]);
        return v;
    endfunction

    function automatic void mdl_apply(bit fill, int s, int w);
        int r;
        r = mdl[s][w];
        if (!fill) begin
            if (r != WAYS - 1) begin
                for (int i = 0; i < WAYS; i++) if (mdl[s][i] == r + 1) mdl[s][i] = r;
                mdl[s][w] = r + 1;
            end
        end else begin
            for (int i = 0; i < WAYS; i++) if (i != w && mdl[s][i] < r) mdl[s][i]++;
            mdl[s][w] = 0;
        end
    endfunction

    task automatic chk_set(int s, string tag);
        int ev;
        look_set = SET_W'(s);
        #1;
        checks++;
        if (look_ranks !== exp_vec(s)) begin
            errors++;
            $display("FAIL %s set %0d ranks: actual=%h expected=%h", tag, s, look_ranks, exp_vec(s));
        end
        ev = 0;
        for (int i = 0; i < WAYS; i++) if (mdl[s][i] == 0) ev = i;
        checks++;
        if (victim_way !== WAY_W'(ev)) begin
            errors++;
            $display("FAIL R2 set %0d victim: actual=%0d expected=%0d", s, victim_way, ev);
        end
    endtask

    task automatic ev(bit fill, int s, int w, string tag);
        upd_valid = 1'b1;
        upd_fill  = fill;
        upd_set   = SET_W'(s);
        upd_way   = WAY_W'(w);
        look_set  = SET_W'(s);
        @(posedge clk);
        #1;
        mdl_apply(fill, s, w);
        chk_set(s, tag);
    endtask

    task automatic all_sets(string tag);
        for (int s = 0; s < SETS; s++) chk_set(s, tag);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int s = 0; s < SETS; s++)
            for (int i = 0; i < WAYS; i++) mdl[s][i] = i;
        repeat (2) @(posedge clk);
        #1;
        all_sets("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        all_sets("R1 after reset");

        // worked example on set 5: ways 3,2,1,0 start at ranks 3,2,1,0
        ev(1'b0, 5, 0, "R3 climb one");
        ev(1'b0, 5, 0, "R3 climb two");
        checks++;
        if (victim_way !== 2'd1) begin
            errors++;
            $display("FAIL R2 example victim: actual=%0d expected=1", victim_way);
        end
        ev(1'b1, 5, 1, "R5 fill at victim");
        ev(1'b0, 5, 3, "R4 top hit");
        ev(1'b0, 5, 3, "R4 top hit again");
        ev(1'b1, 5, 3, "R5 fill from top");
        upd_valid = 1'b0;

        // R8: table walked back to back
        for (int k = 0; k < NVEC; k++)
            ev(VECS[k][VEC_W-1], int'(VECS[k][WAY_W +: SET_W]), int'(VECS[k][WAY_W-1:0]), "R8 table");

        // R9: idle cycles with garbage on the update fields
        upd_valid = 1'b0;
        upd_fill = 1'b1;
        upd_set = 3'd2;
        upd_way = 2'd3;
        repeat (3) @(posedge clk);
        #1;
        all_sets("R9 idle");

        // long stream, few sets
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ev(lfsr[0] & lfsr[3], int'(lfsr[6:5]), int'(lfsr[9:8]), "R7 stream");
        end
        upd_valid = 1'b0;
        @(posedge clk);
        #1;
        all_sets("R6 other sets");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule